// File: doc/BRIEF.md
# Idle-Cycle Self-Test Scheduler for a Paired ALU

This block sits in front of two identical arithmetic units that together form a safety pair. Both units always receive the same operands and opcode from this block. In a cycle where the normal workload issues nothing to the pair, the block borrows the cycle. It drives the next stored test vector into both units. One cycle later it compares the two results, and any difference latches a fault flag.

Testing runs only while the pair has recently executed safety-tagged work. Each safety-tagged operation restarts a recent-use down-counter, and testing is allowed while that counter is non-zero. Progress through the active vectors is tracked inside a repeating fault-detection window of programmable length. When the window's remaining cycles shrink to the number of untested vectors plus the compare latency, the block requests forced idle cycles from the pipeline. This keeps the whole vector set finishing inside the window. A fully matching pass produces a one-cycle pass pulse.

Top module: `pair_idle_selftest`

## Requirements
- R1: After reset, fault, stall_req, pass_pulse and test_issue are low. Vector entry i holds the default operand A = 32'h1000_0000 + i, operand B = the bitwise inverse of operand A, and opcode = i mod 8.
- R2: In any cycle with wl_valid high, no test vector is issued, and alu_opa, alu_opb and alu_opc carry wl_opa, wl_opb and wl_opc.
- R3: A cycle with wl_valid and wl_safety both high reloads the recent-use counter to RECENT_CYC (default 64). Test vectors are issued only in idle cycles while this counter is non-zero. Call the cycle of the last safety operation c. An idle cycle c+64 may still issue a vector, and an idle cycle c+65 may not.
- R4: Within a window, vectors are issued in index order 0 to cfg_vec_count-1, each at most once (cfg_vec_count is 1 to MAX_VEC). During an issue cycle, test_issue is high and the ALU ports carry that vector's fields.
- R5: The two results are compared in the cycle after an issue. A mismatch raises fault in the following cycle and records the index of the failing vector in fault_idx. fault_idx holds the first failure while fault stays set.
- R6: fault stays high until fault_clr is asserted. A clear in a cycle with no mismatch drops fault in the next cycle.
- R7: If every vector in a window matched, pass_pulse is high for exactly one cycle, the cycle after the last compare. No further vector is issued until the next window starts.
- R8: A write with tv_we high stores tv_opa, tv_opb and tv_opc into entry tv_addr, replacing the default contents. Later issues of that entry carry the new fields.
- R9: The window lasts cfg_win_len cycles (at least 2) and then restarts. Let the remaining window cycles count the current cycle. While testing is allowed and the set is incomplete, stall_req rises in the first cycle where the remaining cycles are at most the untested vectors plus one. It stays high until the set completes or the window ends. With 4 vectors, a 20-cycle window and a busy workload, stall_req is high for cycles 16 to 20.
- R10: When a new window starts, the vector index returns to 0, and testing begins again at entry 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wl_valid | input | 1 | Workload operation issued to the pair this cycle |
| wl_safety | input | 1 | Workload operation belongs to a safety-related task |
| wl_opa | input | 32 | Workload operand A |
| wl_opb | input | 32 | Workload operand B |
| wl_opc | input | 3 | Workload opcode |
| alu_opa | output | 32 | Operand A driven to both units |
| alu_opb | output | 32 | Operand B driven to both units |
| alu_opc | output | 3 | Opcode driven to both units |
| alu_a_res | input | 32 | Registered result of the first unit |
| alu_b_res | input | 32 | Registered result of the second unit |
| test_issue | output | 1 | A test vector is on the ALU ports this cycle |
| tv_we | input | 1 | Test-vector write strobe |
| tv_addr | input | 4 | Test-vector entry to write |
| tv_opa | input | 32 | Operand A to store |
| tv_opb | input | 32 | Operand B to store |
| tv_opc | input | 3 | Opcode to store |
| cfg_vec_count | input | 5 | Number of active vector entries |
| cfg_win_len | input | 16 | Fault-detection window length in cycles |
| stall_req | output | 1 | Request to force idle cycles in the pipeline |
| fault_clr | input | 1 | Clears the fault flag |
| fault | output | 1 | Sticky mismatch flag |
| fault_idx | output | 4 | Index of the first failing vector |
| pass_pulse | output | 1 | One-cycle pulse after a fully matching vector set |

## Verification
Some properties are checked on every cycle. Workload cycles never carry a test vector, and in those cycles they pass the workload operands straight through. A result mismatch one cycle after an issue always raises the flag. The flag and its recorded index stay put until a clear, and the pass pulse never lasts two cycles. Other behaviour only directed scenarios can show, because each needs a known stimulus history. This covers the exact boundary of the recent-use counter, the order and contents of the issued vectors after reprogramming, and the precise cycle where the forced-idle request begins and ends inside a short window. It also covers the restart of testing at entry 0 once a new window begins.

// File: rtl/selftest_pkg.sv
package selftest_pkg;
    localparam int OPND_W = 32;
    localparam int OPC_W  = 3;

    typedef struct packed {
        logic [OPND_W-1:0] opa;
        logic [OPND_W-1:0] opb;
        logic [OPC_W-1:0]  opc;
    } vec_t;

    // Contents loaded into entry i at reset.
    function automatic vec_t default_vec(input int unsigned i);
        vec_t v;
        v.opa = 32'h1000_0000 + OPND_W'(i);
        v.opb = ~v.opa;
        v.opc = OPC_W'(i);
        return v;
    endfunction
endpackage

// File: rtl/selftest_vec_store.sv
module selftest_vec_store
    import selftest_pkg::*;
#(
    parameter int MAX_VEC = 16,
    localparam int IDX_W  = $clog2(MAX_VEC)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] waddr,
    input  vec_t             wdata,
    input  logic [IDX_W-1:0] raddr,
    output vec_t             rdata
);
    vec_t mem [MAX_VEC];

    always_ff @(posedge clk) begin
        for (int i = 0; i < MAX_VEC; i++) begin
            if (rst)
                mem[i] <= default_vec(i);
            else if (we && (waddr == IDX_W'(i)))
                mem[i] <= wdata;
        end
    end

    assign rdata = mem[raddr];
endmodule

// File: rtl/selftest_window.sv
module selftest_window #(
    parameter int WIN_W = 16,
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIN_W-1:0] cfg_win_len,
    input  logic             test_en,
    input  logic             done,
    input  logic [CNT_W-1:0] untested,
    output logic             win_end,
    output logic             stall_req
);
    logic [WIN_W-1:0] win_rem;
    logic             hold;
    logic             trigger;

    assign win_end = (win_rem == WIN_W'(1));
    assign trigger = test_en && !done &&
                     (win_rem <= (WIN_W'(untested) + WIN_W'(1)));
    assign stall_req = (trigger || hold) && !done;

    always_ff @(posedge clk) begin
        if (rst || win_end)
            win_rem <= cfg_win_len;
        else
            win_rem <= win_rem - WIN_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst || win_end || done)
            hold <= 1'b0;
        else if (trigger)
            hold <= 1'b1;
    end
endmodule

// File: rtl/selftest_cmp.sv
module selftest_cmp
    import selftest_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chk,
    input  logic [IDX_W-1:0]  chk_idx,
    input  logic [OPND_W-1:0] res_a,
    input  logic [OPND_W-1:0] res_b,
    input  logic              clr,
    output logic              mismatch,
    output logic              fault,
    output logic [IDX_W-1:0]  fault_idx
);
    assign mismatch = chk && (res_a != res_b);

    always_ff @(posedge clk) begin
        if (rst) begin
            fault     <= 1'b0;
            fault_idx <= '0;
        end else begin
            if (mismatch && !fault)
                fault_idx <= chk_idx;
            if (mismatch)
                fault <= 1'b1;
            else if (clr)
                fault <= 1'b0;
        end
    end
endmodule

// File: rtl/pair_idle_selftest.sv
module pair_idle_selftest
    import selftest_pkg::*;
#(
    parameter int MAX_VEC    = 16,
    parameter int WIN_W      = 16,
    parameter int RECENT_CYC = 64,
    localparam int IDX_W     = $clog2(MAX_VEC),
    localparam int CNT_W     = $clog2(MAX_VEC + 1),
    localparam int RECENT_W  = $clog2(RECENT_CYC + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wl_valid,
    input  logic              wl_safety,
    input  logic [OPND_W-1:0] wl_opa,
    input  logic [OPND_W-1:0] wl_opb,
    input  logic [OPC_W-1:0]  wl_opc,
    output logic [OPND_W-1:0] alu_opa,
    output logic [OPND_W-1:0] alu_opb,
    output logic [OPC_W-1:0]  alu_opc,
    input  logic [OPND_W-1:0] alu_a_res,
    input  logic [OPND_W-1:0] alu_b_res,
    output logic              test_issue,
    input  logic              tv_we,
    input  logic [IDX_W-1:0]  tv_addr,
    input  logic [OPND_W-1:0] tv_opa,
    input  logic [OPND_W-1:0] tv_opb,
    input  logic [OPC_W-1:0]  tv_opc,
    input  logic [CNT_W-1:0]  cfg_vec_count,
    input  logic [WIN_W-1:0]  cfg_win_len,
    output logic              stall_req,
    input  logic              fault_clr,
    output logic              fault,
    output logic [IDX_W-1:0]  fault_idx,
    output logic              pass_pulse
);
    logic [RECENT_W-1:0] recent_cnt;
    logic [CNT_W-1:0]    issue_idx;
    logic [IDX_W-1:0]    pend_idx;
    logic                pend, done, win_fail, pass_q;
    logic                test_en, all_issued, last_cmp, win_end, mismatch;
    logic [CNT_W-1:0]    untested;
    vec_t                wvec, rvec;

    assign wvec = '{opa: tv_opa, opb: tv_opb, opc: tv_opc};

    selftest_vec_store #(.MAX_VEC(MAX_VEC)) u_store (
        .clk(clk), .rst(rst), .we(tv_we), .waddr(tv_addr), .wdata(wvec),
        .raddr(issue_idx[IDX_W-1:0]), .rdata(rvec)
    );

    assign test_en    = (recent_cnt != '0);
    assign all_issued = (issue_idx >= cfg_vec_count);
    assign untested   = cfg_vec_count - issue_idx;
    assign test_issue = !wl_valid && test_en && !done && !all_issued && !win_end;
    assign last_cmp   = pend && (CNT_W'(pend_idx) == cfg_vec_count - CNT_W'(1));

    selftest_window #(.WIN_W(WIN_W), .CNT_W(CNT_W)) u_win (
        .clk(clk), .rst(rst), .cfg_win_len(cfg_win_len), .test_en(test_en),
        .done(done), .untested(untested), .win_end(win_end), .stall_req(stall_req)
    );

    selftest_cmp #(.IDX_W(IDX_W)) u_cmp (
        .clk(clk), .rst(rst), .chk(pend), .chk_idx(pend_idx),
        .res_a(alu_a_res), .res_b(alu_b_res), .clr(fault_clr),
        .mismatch(mismatch), .fault(fault), .fault_idx(fault_idx)
    );

    // Shared operand bus to both units: workload first, borrowed cycles otherwise.
    always_comb begin
        if (test_issue) begin
            alu_opa = rvec.opa;
            alu_opb = rvec.opb;
            alu_opc = rvec.opc;
        end else begin
            alu_opa = wl_opa;
            alu_opb = wl_opb;
            alu_opc = wl_opc;
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            recent_cnt <= '0;
        else if (wl_valid && wl_safety)
            recent_cnt <= RECENT_W'(RECENT_CYC);
        else if (test_en)
            recent_cnt <= recent_cnt - RECENT_W'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            issue_idx <= '0;
            pend      <= 1'b0;
            pend_idx  <= '0;
            done      <= 1'b0;
            win_fail  <= 1'b0;
            pass_q    <= 1'b0;
        end else begin
            pend     <= test_issue;
            pend_idx <= issue_idx[IDX_W-1:0];
            pass_q   <= last_cmp && !win_fail && !mismatch;
            if (win_end) begin
                issue_idx <= '0;
                done      <= 1'b0;
                win_fail  <= 1'b0;
            end else begin
                if (test_issue)
                    issue_idx <= issue_idx + CNT_W'(1);
                if (mismatch)
                    win_fail <= 1'b1;
                if (last_cmp) begin
                    done      <= 1'b1;
                    issue_idx <= '0;
                end
            end
        end
    end

    assign pass_pulse = pass_q;
endmodule

// File: rtl/pair_idle_selftest_chk.sv
module pair_idle_selftest_chk
    import selftest_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              wl_valid,
    input logic [OPND_W-1:0] wl_opa,
    input logic [OPND_W-1:0] wl_opb,
    input logic [OPND_W-1:0] alu_opa,
    input logic [OPND_W-1:0] alu_opb,
    input logic [OPND_W-1:0] alu_a_res,
    input logic [OPND_W-1:0] alu_b_res,
    input logic              test_issue,
    input logic              mismatch,
    input logic              fault,
    input logic              fault_clr,
    input logic [IDX_W-1:0]  fault_idx,
    input logic              pass_pulse
);
    // R2: a busy cycle is never borrowed
    a_r2_busy_no_test: assert property (@(posedge clk) disable iff (rst)
        wl_valid |-> !test_issue);

    // R2: workload operands reach the units untouched
    a_r2_busy_passthru: assert property (@(posedge clk) disable iff (rst)
        wl_valid |-> (alu_opa == wl_opa && alu_opb == wl_opb));

    // R5: differing results one cycle after an issue raise the flag
    a_r5_mismatch_flags: assert property (@(posedge clk) disable iff (rst)
        test_issue ##1 (alu_a_res != alu_b_res) |=> fault);

    // R6: flag is sticky without a clear
    a_r6_fault_sticky: assert property (@(posedge clk) disable iff (rst)
        (fault && !fault_clr) |=> fault);

    // R5: recorded index stays on the first failure
    a_r5_idx_hold: assert property (@(posedge clk) disable iff (rst)
        fault |=> $stable(fault_idx));

    // R6: a clear with no new mismatch drops the flag
    a_r6_clear_drops: assert property (@(posedge clk) disable iff (rst)
        (fault_clr && !mismatch) |=> !fault);

    // R7: pass indication lasts one cycle
    a_r7_pass_single: assert property (@(posedge clk) disable iff (rst)
        pass_pulse |=> !pass_pulse);
endmodule

bind pair_idle_selftest pair_idle_selftest_chk #(.IDX_W(IDX_W)) u_chk (
    .clk(clk), .rst(rst), .wl_valid(wl_valid), .wl_opa(wl_opa), .wl_opb(wl_opb),
    .alu_opa(alu_opa), .alu_opb(alu_opb), .alu_a_res(alu_a_res),
    .alu_b_res(alu_b_res), .test_issue(test_issue), .mismatch(mismatch),
    .fault(fault), .fault_clr(fault_clr), .fault_idx(fault_idx),
    .pass_pulse(pass_pulse)
);

// File: tb/pair_idle_selftest_tb.sv
module pair_idle_selftest_tb;
    logic        clk = 1'b0;
    logic        rst;
    logic        wl_valid, wl_safety;
    logic [31:0] wl_opa, wl_opb;
    logic [2:0]  wl_opc;
    logic [31:0] alu_opa, alu_opb, ra, rb;
    logic [2:0]  alu_opc;
    logic        test_issue, tv_we, stall_req, fault_clr, fault, pass_pulse;
    logic [3:0]  tv_addr, fault_idx;
    logic [31:0] tv_opa, tv_opb;
    logic [2:0]  tv_opc;
    logic [4:0]  cfg_vec_count;
    logic [15:0] cfg_win_len;
    logic        inj;
    int          n_chk = 0, n_err = 0, cyc = 0;

    always #4 clk = ~clk;

    pair_idle_selftest u_dut (
        .clk(clk), .rst(rst), .wl_valid(wl_valid), .wl_safety(wl_safety),
        .wl_opa(wl_opa), .wl_opb(wl_opb), .wl_opc(wl_opc),
        .alu_opa(alu_opa), .alu_opb(alu_opb), .alu_opc(alu_opc),
        .alu_a_res(ra), .alu_b_res(rb), .test_issue(test_issue),
        .tv_we(tv_we), .tv_addr(tv_addr), .tv_opa(tv_opa), .tv_opb(tv_opb),
        .tv_opc(tv_opc), .cfg_vec_count(cfg_vec_count), .cfg_win_len(cfg_win_len),
        .stall_req(stall_req), .fault_clr(fault_clr), .fault(fault),
        .fault_idx(fault_idx), .pass_pulse(pass_pulse)
    );

    // Two registered unit models; the second can be corrupted on vector 2.
    always_ff @(posedge clk) begin
        ra <= alu_opa + alu_opb + {29'd0, alu_opc};
        rb <= (alu_opa + alu_opb + {29'd0, alu_opc}) ^
              ((inj && test_issue && alu_opa == 32'h1000_0002) ? 32'h10 : 32'h0);
    end

    task automatic report;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_err++;
            $display("FAIL watchdog: act=%0d exp<=100000 cycles", cyc);
            report();
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic idle_inputs;
        wl_valid = 0; wl_safety = 0; wl_opa = 0; wl_opb = 0; wl_opc = 0;
        tv_we = 0; tv_addr = 0; tv_opa = 0; tv_opb = 0; tv_opc = 0;
        fault_clr = 0;
    endtask

    task automatic do_reset(input int cnt, input int win);
        @(negedge clk);
        rst = 1; inj = 0; idle_inputs();
        cfg_vec_count = 5'(cnt); cfg_win_len = 16'(win);
        repeat (3) @(negedge clk);
        rst = 0;
    endtask

    // Cycle 1 after reset: one safety-tagged workload op.
    task automatic safety_op;
        idle_inputs();
        wl_valid = 1; wl_safety = 1; wl_opa = 32'hCAFE_0001; wl_opb = 32'h2;
        #1;
        check(!test_issue && alu_opa == 32'hCAFE_0001, "R2 safety op passthru", alu_opa, 32'hCAFE_0001);
    endtask

    task automatic t_reset;
        do_reset(4, 1000);
        #1;
        check(!fault && !stall_req && !pass_pulse && !test_issue, "R1 reset outputs",
              {fault, stall_req, pass_pulse, test_issue}, 0);
    endtask

    task automatic t_pass;
        int k = 0, pass_at = -1, bad = 0;
        do_reset(4, 1000);
        safety_op();
        for (int c = 2; c <= 16; c++) begin
            @(negedge clk); idle_inputs(); #1;
            if (test_issue) begin
                if (alu_opa != 32'h1000_0000 + k || alu_opb != ~(32'h1000_0000 + k) ||
                    alu_opc != 3'(k)) bad++;
                k++;
            end
            if (pass_pulse) pass_at = c;
        end
        check(bad == 0, "R1 R4 default vector contents in order", bad, 0);
        check(k == 4, "R4 R7 issue count per window", k, 4);
        check(pass_at == 7, "R7 pass pulse cycle", pass_at, 7);
        check(!fault, "R5 no fault on matching units", fault, 0);
    endtask

    task automatic t_priority;
        int k = 0, bad = 0;
        do_reset(4, 1000);
        safety_op();
        for (int c = 2; c <= 13; c++) begin
            @(negedge clk); idle_inputs();
            wl_valid = (c % 2 == 0); wl_opa = 32'hAB00_0000 + c; wl_opb = 32'h77;
            #1;
            if (wl_valid && (test_issue || alu_opa != wl_opa)) bad++;
            if (test_issue) k++;
        end
        check(bad == 0, "R2 busy cycles untouched", bad, 0);
        check(k == 4, "R4 tests complete in gaps", k, 4);
    endtask

    task automatic t_fault;
        int pass_cnt = 0;
        do_reset(4, 1000);
        inj = 1;
        safety_op();
        for (int c = 2; c <= 5; c++) begin @(negedge clk); idle_inputs(); end
        #1;
        check(!fault, "R5 fault not yet set in compare cycle", fault, 0);
        @(negedge clk); #1;
        check(fault, "R5 fault set after mismatch", fault, 1);
        check(fault_idx == 4'd2, "R5 failing index", fault_idx, 2);
        for (int c = 7; c <= 20; c++) begin
            @(negedge clk); #1;
            if (pass_pulse) pass_cnt++;
        end
        check(pass_cnt == 0, "R7 no pass after mismatch", pass_cnt, 0);
        check(fault && fault_idx == 4'd2, "R6 fault sticky", {fault, fault_idx}, {1'b1, 4'd2});
        inj = 0;
        @(negedge clk); fault_clr = 1;
        @(negedge clk); fault_clr = 0; #1;
        check(!fault, "R6 clear drops fault", fault, 0);
    endtask

    task automatic t_program;
        int k = 0;
        logic [66:0] got = '0;
        do_reset(4, 1000);
        @(negedge clk); idle_inputs();
        tv_we = 1; tv_addr = 4'd1; tv_opa = 32'hDEAD_BEEF; tv_opb = 32'h1; tv_opc = 3'd5;
        @(negedge clk);
        safety_op();
        for (int c = 0; c < 8; c++) begin
            @(negedge clk); idle_inputs(); #1;
            if (test_issue) begin
                if (k == 1) got = {alu_opa, alu_opb, alu_opc};
                k++;
            end
        end
        check(got == {32'hDEAD_BEEF, 32'h1, 3'd5}, "R8 programmed entry issued", got[66:35], 32'hDEAD_BEEF);
    endtask

    task automatic t_window;
        int n_stall = 0, first_stall = -1, k = 0, pass_at = -1;
        logic [31:0] first_new = '0;
        do_reset(4, 20);
        safety_op();
        for (int c = 2; c <= 21; c++) begin
            @(negedge clk); idle_inputs();
            wl_valid = !stall_req; wl_opa = 32'h5500_0000 + c;
            #1;
            if (c <= 20 && stall_req) begin
                n_stall++;
                if (first_stall < 0) first_stall = c;
            end
            if (test_issue) k++;
            if (pass_pulse) pass_at = c;
        end
        check(first_stall == 16, "R9 stall start cycle", first_stall, 16);
        check(n_stall == 5, "R9 stall length", n_stall, 5);
        check(k == 4, "R9 set finished under stall", k, 4);
        check(pass_at == 21, "R7 R9 pass at window end", pass_at, 21);
        k = 0;
        for (int c = 22; c <= 27; c++) begin
            @(negedge clk); idle_inputs(); #1;
            if (test_issue) begin
                if (k == 0) first_new = alu_opa;
                k++;
            end
        end
        check(k == 4 && first_new == 32'h1000_0000, "R10 new window restarts at entry 0", first_new, 32'h1000_0000);
    endtask

    task automatic t_recent(input int busy, input bit expect_issue);
        do_reset(4, 1000);
        safety_op();
        for (int c = 0; c < busy; c++) begin
            @(negedge clk); idle_inputs(); wl_valid = 1; wl_opa = 32'h3;
        end
        @(negedge clk); idle_inputs(); #1;
        check(test_issue == expect_issue, "R3 recent-use boundary", test_issue, expect_issue);
    endtask

    initial begin
        rst = 1; inj = 0; idle_inputs();
        cfg_vec_count = 5'd4; cfg_win_len = 16'd1000;
        t_reset();
        t_pass();
        t_priority();
        t_fault();
        t_program();
        t_window();
        t_recent(63, 1'b1);
        t_recent(64, 1'b0);
        report();
        $finish;
    end
endmodule